// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the memory-mapped register front end of an event timer with a set of comparator channels (eight by default). It accepts single-cycle read and write requests carrying a byte address, a size in bytes and 64 bits of write data. It decodes the address into its own registers or into a channel slot. It owns the free-running 32-bit main counter, the general configuration word and the per-channel interrupt status bits, and it serves a constant capability word.

Only 4-byte and 8-byte accesses that are naturally aligned are honoured. A 4-byte access reaches one 32-bit half of a 64-bit register, selected by address bit 2, and the other half is left as it was. Accesses to channel registers are forwarded on a small internal port with the channel index, the sub-register, steered data and a byte-lane mask. Read data from the channels comes back on the same cycle. The block tells the channels when the counter starts to run or is reloaded, so that they can recompute their next match. It also derives the mask of interrupt-controller pins that a channel may route to, from the pin count it is given.

Top module: `tmr_regfront`

## Requirements
- R1: A request whose size is neither 4 nor 8, or whose address is not a multiple of its size, changes no state and forwards nothing to the channels. If it is a read, it returns 0.
- R2: A 4-byte access with address bit 2 set reaches bits 63:32 of the addressed register, and with bit 2 clear it reaches bits 31:0. The other half keeps its value. A 4-byte read returns the selected half in bits 31:0, with bits 63:32 zero.
- R3: The capability word at offset 0x000 reads as follows: revision 1 in bits 7:0, channel count minus one in bits 12:8, bit 13 (counter size) 0, vendor ID in bits 31:16, and the tick period in femtoseconds, 10^15 / 2^24 = 59604644, in bits 63:32.
- R4: The configuration word at offset 0x010 stores every written bit except bit 1 (legacy routing), which always reads 0. Bit 0 is the counter run enable.
- R5: While bit 0 of the configuration word is 1, the counter at offset 0x0F0 advances by one each clock and wraps at 2^32. While bit 0 is 0, the counter holds its value.
- R6: When bit 0 goes from 0 to 1, counting resumes from the held value, and `resched_o` is 1 for the one cycle after the write.
- R7: Writing 1 to bit n of the status word at offset 0x020 clears status bit n and pulses `chn_clr_o[n]` during the write cycle, but only if that bit was set. Bits written 0 have no effect.
- R8: A 1 on `chn_fire_i[n]` sets status bit n on the next clock edge. A set takes priority over a clear in the same cycle.
- R9: A counter write merges the data into the zero-extended counter and keeps the low 32 bits, so a write to the upper half alone leaves the counter unchanged. If the counter is running, `resched_o` is 1 in the cycle after the write.
- R10: `route_mask_o` is 0xFF000000 for a pin count of 32 or more. For a count p from 20 to 31 it is 0xF shifted left by p-4, and below 20 it is 0.
- R11: A read of an offset that maps to no register returns 0. This includes sub-slot 3 of a channel and slots past the last channel.
- R12: Channel n occupies offsets 0x100+0x20·n, with sub-register 0 (configuration) at +0x00, 1 (comparator) at +0x08 and 2 (message) at +0x10. An access there drives `chn_wr_o` or `chn_rd_o` with that index, sub-register, steered data and lane mask. A read returns `chn_rdata_i`.
- R13: Every read request yields `rsp_valid_o` and `rsp_rdata_o` exactly one clock later, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 write, 0 read |
| req_addr_i | input | 12 | Byte offset |
| req_size_i | input | 4 | Access size in bytes |
| req_wdata_i | input | 64 | Write data, low half used for 4-byte writes |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_rdata_o | output | 64 | Read response data |
| ctl_pins_i | input | 7 | Pin count of the interrupt controller |
| route_mask_o | output | 32 | Pins a channel may route to |
| cnt_o | output | 32 | Main counter |
| cnt_en_o | output | 1 | Counter running |
| resched_o | output | 1 | Channels must recompute their next match |
| chn_fire_i | input | 8 | Per-channel level interrupt set |
| irq_stat_o | output | 8 | Per-channel status bits |
| chn_clr_o | output | 8 | Per-channel clear pulse |
| chn_wr_o | output | 1 | Channel register write |
| chn_rd_o | output | 1 | Channel register read |
| chn_idx_o | output | 3 | Channel index |
| chn_sub_o | output | 2 | Channel sub-register |
| chn_wdata_o | output | 64 | Steered write data |
| chn_wmask_o | output | 64 | Bit mask of the written lanes |
| chn_rdata_i | input | 64 | Read data of the selected channel register |

## Verification
Channel forwarding (`chn_wr_o`, `chn_rd_o`, index, data, mask) and `chn_clr_o` are combinational in the request cycle. The bench therefore samples them 1 ns after it drives the request, before the clock edge. Read data, `resched_o`, the counter, the enable, the configuration and the status bits all change at the edge that takes the request, so the bench reads them at the following falling edge. For counter rates it reads the counter twice and compares the difference with the number of edges between the two sampling edges: five idle cycles between reads give a difference of six. A write to bit 0 of the configuration word counts as a separate case. The edge that stops the counter still advances it once, and the edge that starts it does not.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Register offsets (byte addresses, 8-byte aligned)
    localparam int OFS_CAP         = 'h000;
    localparam int OFS_CFG         = 'h010;
    localparam int OFS_STS         = 'h020;
    localparam int OFS_CNT         = 'h0F0;
    localparam int OFS_CHN         = 'h100;
    localparam int CHN_STRIDE_LOG2 = 5;

    localparam int CFG_RUN_BIT     = 0;
    localparam int CFG_LEGACY_BIT  = 1;
    localparam int CAP_REVISION    = 1;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_CAP,
        RG_CFG,
        RG_STS,
        RG_CNT,
        RG_CHN
    } reg_sel_e;

    typedef enum logic [1:0] {
        CH_CFG = 2'd0,
        CH_CMP = 2'd1,
        CH_MSG = 2'd2,
        CH_RSV = 2'd3
    } chn_sub_e;

    // Constant capability word
    function automatic logic [63:0] cap_word(input int nch, input logic [15:0] vendor,
                                             input int tick_log2);
        logic [63:0] period;
        logic [63:0] w;
        period     = 64'd1_000_000_000_000_000 >> tick_log2;
        w          = '0;
        w[7:0]     = 8'(CAP_REVISION);
        w[12:8]    = 5'(nch - 1);
        w[13]      = 1'b0;
        w[31:16]   = vendor;
        w[63:32]   = period[31:0];
        return w;
    endfunction

endpackage

// File: rtl/tmr_acc_decode.sv
module tmr_acc_decode
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NCH    = 8,
    parameter int IDX_W  = 3
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [3:0]        size_i,
    input  logic [63:0]       wdata_i,
    output logic              ok_o,
    output reg_sel_e          sel_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic [1:0]        sub_o,
    output logic              wide_o,
    output logic              hi_o,
    output logic [63:0]       mask_o,
    output logic [63:0]       data_o
);
    localparam int WORD_W = ADDR_W - 3;
    localparam int SLOT_W = ADDR_W - CHN_STRIDE_LOG2;

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] relw;
    logic [SLOT_W-1:0] slot;
    logic              size_ok;
    logic              align_ok;
    logic              in_chn;

    always_comb begin
        wide_o   = (size_i == 4'd8);
        size_ok  = wide_o || (size_i == 4'd4);
        align_ok = wide_o ? (addr_i[2:0] == 3'b000) : (addr_i[1:0] == 2'b00);
        ok_o     = valid_i && size_ok && align_ok;
        hi_o     = !wide_o && addr_i[2];

        if (wide_o) begin
            mask_o = '1;
            data_o = wdata_i;
        end else if (hi_o) begin
            mask_o = {32'hFFFF_FFFF, 32'h0};
            data_o = {wdata_i[31:0], 32'h0};
        end else begin
            mask_o = {32'h0, 32'hFFFF_FFFF};
            data_o = {32'h0, wdata_i[31:0]};
        end

        word   = addr_i[ADDR_W-1:3];
        relw   = word - WORD_W'(OFS_CHN >> 3);
        slot   = relw[WORD_W-1:2];
        sub_o  = relw[1:0];
        idx_o  = slot[IDX_W-1:0];
        in_chn = (word >= WORD_W'(OFS_CHN >> 3)) && (slot < SLOT_W'(NCH))
                 && (relw[1:0] != CH_RSV);

        sel_o = RG_NONE;
        if (ok_o) begin
            if (word == WORD_W'(OFS_CAP >> 3))      sel_o = RG_CAP;
            else if (word == WORD_W'(OFS_CFG >> 3)) sel_o = RG_CFG;
            else if (word == WORD_W'(OFS_STS >> 3)) sel_o = RG_STS;
            else if (word == WORD_W'(OFS_CNT >> 3)) sel_o = RG_CNT;
            else if (in_chn)                        sel_o = RG_CHN;
        end
    end
endmodule

// File: rtl/tmr_main_count.sv
module tmr_main_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_q_i,
    input  logic             run_d_i,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] wmask_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             resched_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             resched;
    } cnt_st_t;

    cnt_st_t st_q, st_d;

    always_comb begin
        st_d         = st_q;
        st_d.resched = 1'b0;
        if (wr_i) begin
            // zero-extended counter merged with the lanes written
            st_d.cnt     = (st_q.cnt & ~wmask_i) | (wdata_i & wmask_i);
            st_d.resched = run_q_i;
        end else if (run_q_i) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (!run_q_i && run_d_i) begin
            st_d.resched = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign resched_o = st_q.resched;
endmodule

// File: rtl/tmr_status_bank.sv
module tmr_status_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_i,
    input  logic [NCH-1:0] wdata_i,
    input  logic [NCH-1:0] fire_i,
    output logic [NCH-1:0] stat_o,
    output logic [NCH-1:0] clr_o
);
    typedef struct packed {
        logic [NCH-1:0] stat;
    } sts_st_t;

    sts_st_t st_q, st_d;

    for (genvar n = 0; n < NCH; n++) begin : g_chn
        assign clr_o[n] = wr_i && wdata_i[n] && st_q.stat[n];
    end

    always_comb begin
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~clr_o) | fire_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
endmodule

// File: rtl/tmr_route_mask.sv
module tmr_route_mask #(
    parameter int PIN_W   = 7,
    parameter int WIDE_AT = 32,
    parameter int FEW_AT  = 20
) (
    input  logic [PIN_W-1:0] pins_i,
    output logic [31:0]      mask_o
);
    always_comb begin
        if (pins_i >= PIN_W'(WIDE_AT))
            mask_o = 32'hFF00_0000;
        else if (pins_i >= PIN_W'(FEW_AT))
            mask_o = 32'hF << (pins_i - PIN_W'(4));
        else
            mask_o = 32'h0;
    end
endmodule

// File: rtl/tmr_regfront.sv
module tmr_regfront
    import tmr_pkg::*;
#(
    parameter int          NCH       = 8,
    parameter int          ADDR_W    = 12,
    parameter int          PIN_W     = 7,
    parameter int          TICK_LOG2 = 24,
    parameter logic [15:0] VENDOR_ID = 16'h1D0F,
    parameter int          IDX_W     = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [3:0]        req_size_i,
    input  logic [63:0]       req_wdata_i,
    output logic              rsp_valid_o,
    output logic [63:0]       rsp_rdata_o,
    input  logic [PIN_W-1:0]  ctl_pins_i,
    output logic [31:0]       route_mask_o,
    output logic [31:0]       cnt_o,
    output logic              cnt_en_o,
    output logic              resched_o,
    input  logic [NCH-1:0]    chn_fire_i,
    output logic [NCH-1:0]    irq_stat_o,
    output logic [NCH-1:0]    chn_clr_o,
    output logic              chn_wr_o,
    output logic              chn_rd_o,
    output logic [IDX_W-1:0]  chn_idx_o,
    output logic [1:0]        chn_sub_o,
    output logic [63:0]       chn_wdata_o,
    output logic [63:0]       chn_wmask_o,
    input  logic [63:0]       chn_rdata_i
);
    localparam int          CNT_W   = 32;
    localparam logic [63:0] CAP_VAL = cap_word(NCH, VENDOR_ID, TICK_LOG2);

    typedef struct packed {
        logic [63:0] cfg;
        logic        rsp_valid;
        logic [63:0] rsp_data;
    } front_st_t;

    front_st_t st_q, st_d;

    logic        acc_ok;
    reg_sel_e    sel;
    logic        wide;
    logic        lane_hi;
    logic [63:0] lane_mask;
    logic [63:0] lane_data;
    logic        is_rd;
    logic        is_wr;
    logic [63:0] rd_word;

    tmr_acc_decode #(
        .ADDR_W (ADDR_W),
        .NCH    (NCH),
        .IDX_W  (IDX_W)
    ) dec_i (
        .valid_i (req_valid_i),
        .addr_i  (req_addr_i),
        .size_i  (req_size_i),
        .wdata_i (req_wdata_i),
        .ok_o    (acc_ok),
        .sel_o   (sel),
        .idx_o   (chn_idx_o),
        .sub_o   (chn_sub_o),
        .wide_o  (wide),
        .hi_o    (lane_hi),
        .mask_o  (lane_mask),
        .data_o  (lane_data)
    );

    assign is_rd = acc_ok && !req_write_i;
    assign is_wr = acc_ok && req_write_i;

    tmr_main_count #(
        .CNT_W (CNT_W)
    ) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_q_i   (st_q.cfg[CFG_RUN_BIT]),
        .run_d_i   (st_d.cfg[CFG_RUN_BIT]),
        .wr_i      (is_wr && sel == RG_CNT),
        .wdata_i   (lane_data[CNT_W-1:0]),
        .wmask_i   (lane_mask[CNT_W-1:0]),
        .cnt_o     (cnt_o),
        .resched_o (resched_o)
    );

    tmr_status_bank #(
        .NCH (NCH)
    ) sts_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (is_wr && sel == RG_STS),
        .wdata_i (lane_data[NCH-1:0] & lane_mask[NCH-1:0]),
        .fire_i  (chn_fire_i),
        .stat_o  (irq_stat_o),
        .clr_o   (chn_clr_o)
    );

    tmr_route_mask #(
        .PIN_W (PIN_W)
    ) rmask_i (
        .pins_i (ctl_pins_i),
        .mask_o (route_mask_o)
    );

    assign chn_wr_o    = is_wr && sel == RG_CHN;
    assign chn_rd_o    = is_rd && sel == RG_CHN;
    assign chn_wdata_o = lane_data;
    assign chn_wmask_o = lane_mask;

    always_comb begin
        case (sel)
            RG_CAP:  rd_word = CAP_VAL;
            RG_CFG:  rd_word = st_q.cfg;
            RG_STS:  rd_word = {{(64-NCH){1'b0}}, irq_stat_o};
            RG_CNT:  rd_word = {{(64-CNT_W){1'b0}}, cnt_o};
            RG_CHN:  rd_word = chn_rdata_i;
            default: rd_word = 64'h0;
        endcase
    end

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = req_valid_i && !req_write_i;
        st_d.rsp_data  = 64'h0;
        if (is_rd) begin
            if (wide)         st_d.rsp_data = rd_word;
            else if (lane_hi) st_d.rsp_data = {32'h0, rd_word[63:32]};
            else              st_d.rsp_data = {32'h0, rd_word[31:0]};
        end
        if (is_wr && sel == RG_CFG) begin
            st_d.cfg = (st_q.cfg & ~lane_mask) | (lane_data & lane_mask);
        end
        st_d.cfg[CFG_LEGACY_BIT] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid_o = st_q.rsp_valid;
    assign rsp_rdata_o = st_q.rsp_data;
    assign cnt_en_o    = st_q.cfg[CFG_RUN_BIT];
endmodule

// File: rtl/tmr_regfront_chk.sv
module tmr_regfront_chk
    import tmr_pkg::*;
#(
    parameter int NCH    = 8,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid_i,
    input logic              req_write_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic [3:0]        req_size_i,
    input logic              rsp_valid_o,
    input logic [63:0]       rsp_rdata_o,
    input logic [31:0]       cnt_o,
    input logic              cnt_en_o,
    input logic              resched_o,
    input logic [NCH-1:0]    chn_fire_i,
    input logic [NCH-1:0]    irq_stat_o,
    input logic [NCH-1:0]    chn_clr_o,
    input logic              chn_wr_o,
    input logic              chn_rd_o
);
    logic bad_size;
    logic cnt_touch;
    logic rd_req;

    assign bad_size  = (req_size_i != 4'd4) && (req_size_i != 4'd8);
    assign cnt_touch = req_valid_i && req_write_i
                       && (req_addr_i[ADDR_W-1:3] == (ADDR_W-3)'(OFS_CNT >> 3));
    assign rd_req    = req_valid_i && !req_write_i;

    AST_BAD_SIZE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && bad_size) |-> (!chn_wr_o && !chn_rd_o)); // R1
    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && bad_size) |=> (rsp_valid_o && rsp_rdata_o == 64'h0)); // R1
    AST_LEGACY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && req_size_i == 4'd8 && req_addr_i == ADDR_W'(OFS_CFG)) |=> !rsp_rdata_o[1]); // R4
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_o && !cnt_touch) |=> $stable(cnt_o)); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_o && !cnt_touch) |=> (cnt_o == $past(cnt_o) + 32'd1)); // R5
    AST_RESCHED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        resched_o |-> cnt_en_o); // R6
    AST_CLR_WAS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((chn_clr_o & ~irq_stat_o) == '0)); // R7
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (|chn_clr_o) |=> ((irq_stat_o & $past(chn_clr_o & ~chn_fire_i)) == '0)); // R7
    AST_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|chn_fire_i) |=> ((irq_stat_o & $past(chn_fire_i)) == $past(chn_fire_i))); // R8
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid_o); // R13
    AST_RSP_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rsp_valid_o); // R13
endmodule

bind tmr_regfront tmr_regfront_chk #(
    .NCH    (NCH),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_size_i  (req_size_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_rdata_o (rsp_rdata_o),
    .cnt_o       (cnt_o),
    .cnt_en_o    (cnt_en_o),
    .resched_o   (resched_o),
    .chn_fire_i  (chn_fire_i),
    .irq_stat_o  (irq_stat_o),
    .chn_clr_o   (chn_clr_o),
    .chn_wr_o    (chn_wr_o),
    .chn_rd_o    (chn_rd_o)
);

// File: tb/tmr_regfront_tb_top.sv
`timescale 1ns/1ps
module tmr_regfront_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [3:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic [63:0] rsp_rdata;
    logic [6:0]  ctl_pins = 7'd24;
    logic [31:0] route_mask;
    logic [31:0] cnt;
    logic        cnt_en;
    logic        resched;
    logic [7:0]  chn_fire = '0;
    logic [7:0]  irq_stat;
    logic [7:0]  chn_clr;
    logic        chn_wr;
    logic        chn_rd;
    logic [2:0]  chn_idx;
    logic [1:0]  chn_sub;
    logic [63:0] chn_wdata;
    logic [63:0] chn_wmask;
    logic [63:0] chn_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    logic        cap_wr, cap_rd;
    logic [2:0]  cap_idx;
    logic [1:0]  cap_sub;
    logic [63:0] cap_wdata, cap_wmask;
    logic [7:0]  cap_clr;

    always #2.5 clk = ~clk;

    // Channel read model: tags index and sub-register in both halves
    assign chn_rdata = {16'hC4A5, 5'b0, chn_idx, 6'b0, chn_sub,
                        16'h7E11, 5'b0, chn_idx, 6'b0, chn_sub};

    tmr_regfront dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid_i  (req_valid),
        .req_write_i  (req_write),
        .req_addr_i   (req_addr),
        .req_size_i   (req_size),
        .req_wdata_i  (req_wdata),
        .rsp_valid_o  (rsp_valid),
        .rsp_rdata_o  (rsp_rdata),
        .ctl_pins_i   (ctl_pins),
        .route_mask_o (route_mask),
        .cnt_o        (cnt),
        .cnt_en_o     (cnt_en),
        .resched_o    (resched),
        .chn_fire_i   (chn_fire),
        .irq_stat_o   (irq_stat),
        .chn_clr_o    (chn_clr),
        .chn_wr_o     (chn_wr),
        .chn_rd_o     (chn_rd),
        .chn_idx_o    (chn_idx),
        .chn_sub_o    (chn_sub),
        .chn_wdata_o  (chn_wdata),
        .chn_wmask_o  (chn_wmask),
        .chn_rdata_i  (chn_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%016h expected=0x%016h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic capture();
        cap_wr = chn_wr; cap_rd = chn_rd; cap_idx = chn_idx; cap_sub = chn_sub;
        cap_wdata = chn_wdata; cap_wmask = chn_wmask; cap_clr = chn_clr;
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [3:0] sz, input logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = sz; req_wdata = d;
        #1 capture();
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [3:0] sz, output logic [63:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        #1 capture();
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R13 rsp_valid after read", 64'(rsp_valid), 64'd1);
        d = rsp_rdata;
    endtask

    task automatic t_reset();
        chk("R5 reset counter", 64'(cnt), 64'd0);
        chk("R5 reset enable", 64'(cnt_en), 64'd0);
        chk("R7 reset status", 64'(irq_stat), 64'd0);
        chk("R13 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R6 reset resched", 64'(resched), 64'd0);
    endtask

    task automatic t_cap();
        logic [63:0] d;
        bus_read(12'h000, 4'd8, d);
        chk("R3 capability 8-byte", d, 64'h038D_7EA4_1D0F_0701);
        bus_read(12'h004, 4'd4, d);
        chk("R3 capability upper half", d, 64'h0000_0000_038D_7EA4);
        bus_read(12'h000, 4'd4, d);
        chk("R2 capability lower half", d, 64'h0000_0000_1D0F_0701);
        idle(1);
        chk("R13 no rsp_valid when idle", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_config();
        logic [63:0] d;
        bus_write(12'h010, 4'd8, 64'hFFFF_0000_0000_00F2);
        bus_read(12'h010, 4'd8, d);
        chk("R4 legacy bit cleared", d, 64'hFFFF_0000_0000_00F0);
        bus_write(12'h014, 4'd4, 64'h0000_0000_1234_5678);
        bus_read(12'h010, 4'd8, d);
        chk("R2 upper-half write keeps lower", d, 64'h1234_5678_0000_00F0);
        bus_read(12'h014, 4'd4, d);
        chk("R2 upper-half read", d, 64'h0000_0000_1234_5678);
    endtask

    task automatic t_bad_access();
        logic [63:0] d;
        bus_write(12'h010, 4'd2, 64'h0);
        bus_write(12'h014, 4'd8, 64'h0);
        bus_write(12'h012, 4'd4, 64'h1);
        bus_write(12'h011, 4'd1, 64'h1);
        bus_read(12'h010, 4'd8, d);
        chk("R1 bad writes ignored", d, 64'h1234_5678_0000_00F0);
        chk("R1 bad write no enable", 64'(cnt_en), 64'd0);
        bus_read(12'h010, 4'd1, d);
        chk("R1 size-1 read zero", d, 64'h0);
        bus_read(12'h004, 4'd8, d);
        chk("R1 misaligned 8-byte read zero", d, 64'h0);
        bus_read(12'h012, 4'd4, d);
        chk("R1 misaligned 4-byte read zero", d, 64'h0);
        bus_write(12'h140, 4'd2, 64'h55);
        chk("R1 bad size not forwarded", 64'(cap_wr), 64'd0);
    endtask

    task automatic t_unmapped();
        logic [63:0] d;
        bus_read(12'h008, 4'd8, d);
        chk("R11 offset 0x008", d, 64'h0);
        bus_read(12'h030, 4'd8, d);
        chk("R11 offset 0x030", d, 64'h0);
        bus_read(12'h118, 4'd8, d);
        chk("R11 channel sub-slot 3", d, 64'h0);
        chk("R11 sub-slot 3 not forwarded", 64'(cap_rd), 64'd0);
        bus_read(12'h200, 4'd8, d);
        chk("R11 slot past last channel", d, 64'h0);
        bus_read(12'hFF8, 4'd8, d);
        chk("R11 top offset", d, 64'h0);
    endtask

    task automatic t_counter_idle();
        logic [63:0] d;
        bus_write(12'h0F0, 4'd8, 64'hDEAD_BEEF_0000_0100);
        chk("R9 no resched while stopped", 64'(resched), 64'd0);
        bus_read(12'h0F0, 4'd8, d);
        chk("R9 8-byte write keeps low 32", d, 64'h0000_0000_0000_0100);
        bus_write(12'h0F4, 4'd4, 64'h0000_0000_0000_FFFF);
        chk("R9 upper-half write no change", 64'(cnt), 64'h100);
        bus_write(12'h0F0, 4'd4, 64'h0000_0000_FFFF_FFF0);
        chk("R9 lower-half write", 64'(cnt), 64'hFFFF_FFF0);
        idle(3);
        chk("R5 stopped counter holds", 64'(cnt), 64'hFFFF_FFF0);
    endtask

    task automatic t_counter_run();
        logic [63:0] r1, r2;
        logic [31:0] held;
        bus_write(12'h010, 4'd4, 64'h1);
        chk("R6 enable", 64'(cnt_en), 64'd1);
        chk("R6 resumes from held value", 64'(cnt), 64'hFFFF_FFF0);
        chk("R6 resched on enable", 64'(resched), 64'd1);
        idle(1);
        chk("R6 resched one cycle", 64'(resched), 64'd0);
        idle(19);
        chk("R5 counter wraps", 64'(cnt), 64'h4);
        bus_read(12'h0F0, 4'd8, r1);
        idle(5);
        bus_read(12'h0F0, 4'd8, r2);
        chk("R5 one step per clock", r2 - r1, 64'd6);
        bus_write(12'h0F0, 4'd4, 64'h1000);
        chk("R9 write while running", 64'(cnt), 64'h1000);
        chk("R9 resched on write while running", 64'(resched), 64'd1);
        idle(1);
        chk("R9 counting after write", 64'(cnt), 64'h1001);
        bus_write(12'h010, 4'd4, 64'h0);
        chk("R5 disable", 64'(cnt_en), 64'd0);
        held = cnt;
        idle(5);
        chk("R5 frozen after disable", 64'(cnt), 64'(held));
        chk("R6 no resched on disable", 64'(resched), 64'd0);
        bus_write(12'h010, 4'd4, 64'h1);
        chk("R6 re-enable keeps held", 64'(cnt), 64'(held));
        chk("R6 resched on re-enable", 64'(resched), 64'd1);
        idle(3);
        chk("R6 counting resumed", 64'(cnt), 64'(held + 32'd3));
        bus_read(12'h010, 4'd8, r1);
        chk("R4 config after enable writes", r1, 64'h1234_5678_0000_0001);
    endtask

    task automatic t_status();
        logic [63:0] d;
        chn_fire = 8'hA5;
        @(negedge clk);
        chn_fire = 8'h00;
        chk("R8 fire sets status", 64'(irq_stat), 64'hA5);
        bus_read(12'h020, 4'd8, d);
        chk("R8 status read", d, 64'hA5);
        bus_write(12'h020, 4'd8, 64'h0F);
        chk("R7 clear pulse only set bits", 64'(cap_clr), 64'h05);
        chk("R7 status after clear", 64'(irq_stat), 64'hA0);
        bus_write(12'h020, 4'd8, 64'h0F);
        chk("R7 no pulse for clear bits", 64'(cap_clr), 64'h00);
        bus_write(12'h020, 4'd8, 64'h00);
        chk("R7 writing 0 no effect", 64'(irq_stat), 64'hA0);
        bus_write(12'h024, 4'd4, 64'hFF);
        chk("R7 upper-half write no clear", 64'(cap_clr), 64'h00);
        chk("R7 status kept", 64'(irq_stat), 64'hA0);
        bus_write(12'h020, 4'd4, 64'hF0);
        chk("R7 clear remaining", 64'(cap_clr), 64'hA0);
        chk("R7 status empty", 64'(irq_stat), 64'h00);
    endtask

    task automatic t_channel();
        logic [63:0] d;
        bus_write(12'h14C, 4'd4, 64'h0000_0000_CAFE_F00D);
        chk("R12 write forwarded", 64'(cap_wr), 64'd1);
        chk("R12 write index", 64'(cap_idx), 64'd2);
        chk("R12 write sub comparator", 64'(cap_sub), 64'd1);
        chk("R2 channel upper data", cap_wdata, 64'hCAFE_F00D_0000_0000);
        chk("R2 channel upper mask", cap_wmask, 64'hFFFF_FFFF_0000_0000);
        bus_write(12'h160, 4'd8, 64'h0123_4567_89AB_CDEF);
        chk("R12 8-byte index", 64'(cap_idx), 64'd3);
        chk("R12 8-byte sub config", 64'(cap_sub), 64'd0);
        chk("R12 8-byte mask", cap_wmask, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R12 8-byte data", cap_wdata, 64'h0123_4567_89AB_CDEF);
        bus_read(12'h1F0, 4'd8, d);
        chk("R12 read forwarded", 64'(cap_rd), 64'd1);
        chk("R12 read message reg of last channel", d, 64'hC4A5_0702_7E11_0702);
        bus_read(12'h164, 4'd4, d);
        chk("R2 channel upper-half read", d, 64'h0000_0000_C4A5_0300);
    endtask

    task automatic t_route();
        logic [6:0] pins [7] = '{7'd32, 7'd40, 7'd31, 7'd24, 7'd20, 7'd19, 7'd0};
        logic [31:0] exp [7] = '{32'hFF00_0000, 32'hFF00_0000, 32'h7800_0000,
                                 32'h00F0_0000, 32'h000F_0000, 32'h0, 32'h0};
        for (int i = 0; i < 7; i++) begin
            ctl_pins = pins[i];
            #1;
            chk($sformatf("R10 route mask pins=%0d", pins[i]), 64'(route_mask), 64'(exp[i]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cap();
        t_config();
        t_bad_access();
        t_unmapped();
        t_counter_idle();
        t_counter_run();
        t_status();
        t_channel();
        t_route();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule